// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a small queue of one-byte status records, one per finished transmission, so that a host can inspect them one at a time. A transmit engine presents a completion on a push strobe along with its error flags. The block turns that completion into a status byte and appends it behind any earlier ones. The host always sees the oldest held record on a read port. A write strobe on that port discards the record. While the queue holds a record worth reporting, the block drives a completion indication toward an interrupt unit. It also tracks whether the transmitter may keep running: a jabber or underrun completion freezes it until a reset command.

When the queue is already full, a further completion is not stored. Instead the loss is marked inside the oldest record, so the host learns about it when it reads that record. Maximum-collision completions are reported like the other errors, but they leave the transmitter running. A transmit reset command and the synchronous global reset both flush the queue and restart the transmitter.

Top module: `tx_status_stack`

## Requirements
- R1: A stored record reads as bit 7 = 1 (complete), bit 6 = interrupt-on-success requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow (0 when stored), bits 1:0 = 0. It appears on `status_rd` one cycle after the push when the queue was empty.
- R2: Records leave in arrival order, and up to DEPTH (default 4) records are held.
- R3: A pulse on `host_pop` removes the oldest record, and the next record shows one cycle later. The strobe carries no data.
- R4: With the queue empty, `status_rd` reads 0x00, and `host_pop` changes nothing.
- R5: A push into a full queue with no pop in the same cycle is dropped, and it sets bit 2 of the oldest record.
- R6: A push and a pop in the same cycle on a full queue both take effect, and no overflow is marked.
- R7: A push with jabber or underrun set drives `tx_enabled` low from the next cycle. While `tx_enabled` is low, pushes are ignored.
- R8: A push with only maximum collisions flagged leaves `tx_enabled` high.
- R9: `tx_done_irq` is high exactly while some held record has any of bits 6:2 set.
- R10: `rst` or `tx_reset_cmd` empties the queue, clears any overflow and sets `tx_enabled` high at the next edge, taking priority over a push in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous global reset, active high |
| tx_reset_cmd | input | 1 | Transmit reset command, synchronous |
| push_valid | input | 1 | Completion strobe from the transmit engine |
| push_intr_req | input | 1 | Interrupt on success was requested |
| push_jabber | input | 1 | Jabber error |
| push_underrun | input | 1 | Underrun error |
| push_max_coll | input | 1 | Maximum collisions reached |
| host_pop | input | 1 | Host write strobe on the status port; pops the oldest record |
| status_rd | output | 8 | Oldest held record, or 0x00 when empty |
| tx_enabled | output | 1 | Transmitter allowed to run |
| tx_done_irq | output | 1 | Completion indication to the interrupt unit |

## Verification
A corrupted head or tail pointer shows on `status_rd` at the very next pop, as a record out of order or a stale value where 0x00 is expected. A stuck valid bit shows the same way, as a stale value in place of 0x00, or it keeps `tx_done_irq` high after the last pop. An overflow mark placed on the wrong record surfaces only when the host reaches that record, so the bench pops every record of a full queue. A wrong freeze state appears on `tx_enabled` one cycle after the offending push. It also appears as a missing record after a later push has been dropped.

// File: rtl/tx_status_stack.sv
module tx_status_stack #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_reset_cmd,
  input  logic       push_valid,
  input  logic       push_intr_req,
  input  logic       push_jabber,
  input  logic       push_underrun,
  input  logic       push_max_coll,
  input  logic       host_pop,
  output logic [7:0] status_rd,
  output logic       tx_enabled,
  output logic       tx_done_irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [5:0]       slot [DEPTH];
  logic [DEPTH-1:0] held;
  logic [PW-1:0]    head, tail;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  wire empty   = !held[head];
  wire full    = held[tail];
  wire accept  = push_valid && tx_enabled;
  wire do_pop  = host_pop && !empty;
  wire do_push = accept && (!full || do_pop);
  wire lose    = accept && full && !do_pop;

  always_ff @(posedge clk) begin
    if (rst || tx_reset_cmd) begin
      held       <= '0;
      head       <= '0;
      tail       <= '0;
      tx_enabled <= 1'b1;
    end else begin
      if (do_pop) begin
        held[head] <= 1'b0;
        head       <= adv(head);
      end
      if (do_push) begin
        slot[tail] <= {1'b1, push_intr_req, push_jabber, push_underrun, push_max_coll, 1'b0};
        held[tail] <= 1'b1;
        tail       <= adv(tail);
      end
      if (lose)
        slot[head][0] <= 1'b1;
      if (accept && (push_jabber || push_underrun))
        tx_enabled <= 1'b0;
    end
  end

  assign status_rd = empty ? 8'h00 : {slot[head], 2'b00};

  always_comb begin
    tx_done_irq = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (held[i] && slot[i][5] && (|slot[i][4:0]))
        tx_done_irq = 1'b1;
  end
endmodule

// File: rtl/tx_status_stack_chk.sv
module tx_status_stack_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_reset_cmd,
  input logic       push_valid,
  input logic       push_jabber,
  input logic       push_underrun,
  input logic       push_max_coll,
  input logic       host_pop,
  input logic [7:0] status_rd,
  input logic       tx_enabled,
  input logic       tx_done_irq
);
  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    status_rd[1:0] == 2'b00);

  a_r4_empty_pop_idle: assert property (@(posedge clk) disable iff (rst)
    (status_rd == 8'h00 && host_pop && !push_valid && !tx_reset_cmd) |=> status_rd == 8'h00);

  a_r7_freeze_on_fault: assert property (@(posedge clk) disable iff (rst)
    (push_valid && tx_enabled && (push_jabber || push_underrun) && !tx_reset_cmd) |=> !tx_enabled);

  a_r7_freeze_sticky: assert property (@(posedge clk) disable iff (rst)
    (!tx_enabled && !tx_reset_cmd) |=> !tx_enabled);

  a_r8_maxcoll_runs: assert property (@(posedge clk) disable iff (rst)
    (push_valid && tx_enabled && push_max_coll && !push_jabber && !push_underrun && !tx_reset_cmd)
      |=> tx_enabled);

  a_r9_irq_needs_record: assert property (@(posedge clk) disable iff (rst)
    tx_done_irq |-> status_rd[7]);

  a_r10_cmd_flushes: assert property (@(posedge clk) disable iff (rst)
    tx_reset_cmd |=> (status_rd == 8'h00 && tx_enabled && !tx_done_irq));
endmodule

bind tx_status_stack tx_status_stack_chk chk_i (
  .clk(clk), .rst(rst), .tx_reset_cmd(tx_reset_cmd), .push_valid(push_valid),
  .push_jabber(push_jabber), .push_underrun(push_underrun), .push_max_coll(push_max_coll),
  .host_pop(host_pop), .status_rd(status_rd), .tx_enabled(tx_enabled), .tx_done_irq(tx_done_irq)
);

// File: tb/tx_status_stack_tb_top.sv
module tx_status_stack_tb_top;
  logic clk = 1'b0;
  logic rst, tx_reset_cmd, push_valid, push_intr_req, push_jabber, push_underrun, push_max_coll, host_pop;
  logic [7:0] status_rd;
  logic tx_enabled, tx_done_irq;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tx_status_stack #(.DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .tx_reset_cmd(tx_reset_cmd), .push_valid(push_valid),
    .push_intr_req(push_intr_req), .push_jabber(push_jabber), .push_underrun(push_underrun),
    .push_max_coll(push_max_coll), .host_pop(host_pop), .status_rd(status_rd),
    .tx_enabled(tx_enabled), .tx_done_irq(tx_done_irq)
  );

  // [20:17] req, [16] push, [15] intr, [14] jab, [13] und, [12] maxcoll,
  // [11] pop, [10] tx reset, [9:2] expected read, [1] expected enable, [0] expected irq
  localparam int NV = 28;
  localparam logic [20:0] VEC [NV] = '{
    {4'd10, 7'b0000000, 8'h00, 1'b1, 1'b0},  // R10 idle after reset
    {4'd4,  7'b0000010, 8'h00, 1'b1, 1'b0},  // R4 pop on empty
    {4'd1,  7'b1000000, 8'h80, 1'b1, 1'b0},  // R1 plain record, R9 no irq
    {4'd9,  7'b1100000, 8'h80, 1'b1, 1'b1},  // R9 intr request held
    {4'd2,  7'b1000100, 8'h80, 1'b1, 1'b1},  // R2
    {4'd2,  7'b1100000, 8'h80, 1'b1, 1'b1},  // R2 full
    {4'd5,  7'b1000100, 8'h84, 1'b1, 1'b1},  // R5 overflow marks oldest
    {4'd3,  7'b0000010, 8'hC0, 1'b1, 1'b1},  // R3
    {4'd2,  7'b0000010, 8'h88, 1'b1, 1'b1},  // R2 order
    {4'd2,  7'b0000010, 8'hC0, 1'b1, 1'b1},  // R2 dropped one absent
    {4'd4,  7'b0000010, 8'h00, 1'b1, 1'b0},  // R4 empty again
    {4'd1,  7'b1000000, 8'h80, 1'b1, 1'b0},  // R1
    {4'd3,  7'b1100010, 8'hC0, 1'b1, 1'b1},  // R3 pop and push together
    {4'd4,  7'b0000010, 8'h00, 1'b1, 1'b0},  // R4
    {4'd2,  7'b1000000, 8'h80, 1'b1, 1'b0},  // R2
    {4'd2,  7'b1000000, 8'h80, 1'b1, 1'b0},  // R2
    {4'd2,  7'b1000000, 8'h80, 1'b1, 1'b0},  // R2
    {4'd2,  7'b1000000, 8'h80, 1'b1, 1'b0},  // R2 full
    {4'd6,  7'b1100010, 8'h80, 1'b1, 1'b1},  // R6 push with pop on full
    {4'd10, 7'b0000001, 8'h00, 1'b1, 1'b0},  // R10 tx reset flush
    {4'd8,  7'b1000100, 8'h88, 1'b1, 1'b1},  // R8 max collisions keep running
    {4'd7,  7'b1001000, 8'h88, 1'b0, 1'b1},  // R7 underrun freezes
    {4'd7,  7'b1100000, 8'h88, 1'b0, 1'b1},  // R7 push while frozen
    {4'd7,  7'b0000010, 8'h90, 1'b0, 1'b1},  // R7
    {4'd7,  7'b0000010, 8'h00, 1'b0, 1'b0},  // R7 frozen push was dropped
    {4'd10, 7'b1100001, 8'h00, 1'b1, 1'b0},  // R10 reset beats push
    {4'd7,  7'b1010000, 8'hA0, 1'b0, 1'b1},  // R7 jabber freezes
    {4'd10, 7'b0000001, 8'h00, 1'b1, 1'b0}   // R10 unfreeze
  };

  task automatic drive(input logic [6:0] s, input logic grst);
    @(negedge clk);
    {push_valid, push_intr_req, push_jabber, push_underrun, push_max_coll, host_pop, tx_reset_cmd} = s;
    rst = grst;
    @(posedge clk);
    @(negedge clk);
    {push_valid, push_intr_req, push_jabber, push_underrun, push_max_coll, host_pop, tx_reset_cmd} = '0;
    rst = 1'b0;
  endtask

  task automatic check(input int req, input logic [7:0] rd, input logic en, input logic irq);
    checks++;
    if (status_rd !== rd || tx_enabled !== en || tx_done_irq !== irq) begin
      errors++;
      $display("FAIL R%0d: rd=%h en=%b irq=%b expected rd=%h en=%b irq=%b",
               req, status_rd, tx_enabled, tx_done_irq, rd, en, irq);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    {push_valid, push_intr_req, push_jabber, push_underrun, push_max_coll, host_pop, tx_reset_cmd} = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(10, 8'h00, 1'b1, 1'b0);  // R10 reset state

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16:10], 1'b0);
      check(int'(VEC[i][20:17]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R10 global reset with records held
    drive(7'b1000000, 1'b0);
    drive(7'b1100000, 1'b0);
    check(9, 8'h80, 1'b1, 1'b1);
    drive(7'b0000000, 1'b1);
    check(10, 8'h00, 1'b1, 1'b0);
    drive(7'b1100000, 1'b0);
    check(1, 8'hC0, 1'b1, 1'b1);

    // R10 overflow cleared by tx reset: refill after an overflow
    for (int i = 0; i < 4; i++) drive(7'b1000000, 1'b0);
    drive(7'b1000100, 1'b0);
    check(5, 8'hC4, 1'b1, 1'b1);
    drive(7'b0000001, 1'b0);
    drive(7'b1000000, 1'b0);
    check(10, 8'h80, 1'b1, 1'b0);
    drive(7'b0000010, 1'b0);
    check(4, 8'h00, 1'b1, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule